// File: doc/BRIEF.md
# Locked Watchdog Timer with Two-Write Feed Key

This block is a watchdog peripheral on a simple register bus. A down-counter reloads from a programmable reload value and counts down once every four clocks. If software does not service it, the block asks the system for a reset. Software services it with a two-write key on a dedicated key register. It writes 0xAA first and then 0x55.

Arming takes two steps. Software first sets the enable bit and then completes one valid key sequence. After that the watchdog runs and cannot be stopped.

Once the watchdog is armed, a broken key sequence requests a reset at once. A sequence is broken if the second write is wrong, or if any other bus access falls between the two key writes.

Expiry has two outcomes, chosen by a mode bit:
- a one-cycle reset request pulse, or
- a sticky timeout flag that software clears.

Top module: `wdog_feedlock`

## Requirements
- R1: After reset:
  - the mode register (offset 0x0) reads 0;
  - the reload register (offset 0x4) reads 0xFF;
  - the count register (offset 0xC) reads 0xFF;
  - a read of the key register (offset 0x8) returns 0;
  - `wdt_rst_req` is low.
- R2: The reload register holds 24 bits. A write below 0xFF stores 0xFF. A write above 0xFFFFFF stores 0xFFFFFF. Any other value is stored as written.
- R3: The counter holds its value until the watchdog is armed. Setting mode bit 0 (enable) alone does not arm it. A valid key sequence made while enable is clear reloads the counter but does not arm it. Writing the reload register does not change the count.
- R4: A valid key sequence is a write of 0xAA (in data bits 7:0) to offset 0x8, followed by a write of 0x55 to offset 0x8 as the very next bus access. It loads the counter from the reload value. If enable is set, it arms the watchdog.
- R5: While armed, the count drops by one on every fourth clock. The first decrement happens on the fourth rising edge after the edge that completed the key sequence.
- R6: Mode bit 1 selects reset on expiry. With bit 1 set, the counter expires on the tick that finds it at zero. It then reloads and keeps running. `wdt_rst_req` is high for exactly one cycle after the edge 4*(reload+1) clocks after the completing key write.
- R7: With mode bit 1 clear, expiry sets mode bit 2 (timeout flag) and gives no reset pulse. Writing 0 to bit 2 clears the flag. Writing 1 to bit 2 leaves it unchanged.
- R8: Once enable is set, a mode write with bit 0 at 0 does not clear it.
- R9: While armed, a write of 0xAA followed by a key write of any other byte (0xAA included) produces a one-cycle reset request. While not armed, the same pattern produces none.
- R10: Any bus access other than a key write between the two key writes aborts the sequence. This includes a read of any register. The abort gives a reset request when armed and none when not armed.
- R11: The count register is read-only and returns the count of the cycle in which it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and watchdog clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A bus access occurs this cycle |
| acc_write | input | 1 | The access is a write (read when low) |
| acc_addr | input | 4 | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the addressed register, same cycle |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
Key sequences are tried in four shapes:
- the correct pair;
- a wrong second byte;
- a repeated first byte;
- a first byte followed by a read.

Each shape is applied both before and after arming, which separates "ignored" from "reset at once". Count reads are placed just before and just after the fourth clock following a feed, which pins down the prescaler phase. The expiry pulse is timed against the feed edge at the minimum reload value. The same expiry is repeated with the reset select cleared, which tells the pulse path apart from the sticky flag path.

// File: rtl/wdog_feedlock_pkg.sv
`timescale 1ns/1ps
package wdog_feedlock_pkg;

  typedef enum logic [0:0] {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_e;

  localparam logic [7:0] KEY_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_CLOSE = 8'h55;

  localparam logic [3:0] OFS_MODE   = 4'h0;
  localparam logic [3:0] OFS_RELOAD = 4'h4;
  localparam logic [3:0] OFS_KEY    = 4'h8;
  localparam logic [3:0] OFS_COUNT  = 4'hC;

  // Saturate a written reload value into [lo, hi].
  function automatic logic [31:0] clamp_reload(input logic [31:0] v,
                                               input logic [31:0] lo,
                                               input logic [31:0] hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction

  // Next value of the down-counter on a prescaled tick.
  function automatic logic [31:0] count_step(input logic [31:0] cur,
                                             input logic [31:0] reload);
    return (cur == 32'd0) ? reload : cur - 32'd1;
  endfunction

endpackage

// File: rtl/wdog_prescale.sv
`timescale 1ns/1ps
module wdog_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) phase_q <= '0;
    else if (phase_q == LAST)      phase_q <= '0;
    else                           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/wdog_key_seq.sv
`timescale 1ns/1ps
module wdog_key_seq
  import wdog_feedlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       other_acc,
  input  logic       armed,
  output logic       feed_ok,
  output logic       feed_bad,
  output logic       key_half
);
  key_state_e st_q, st_d;
  logic       broken;

  always_comb begin
    st_d    = st_q;
    feed_ok = 1'b0;
    broken  = 1'b0;
    case (st_q)
      KEY_IDLE: if (key_wr && key_byte == KEY_OPEN) st_d = KEY_HALF;
      KEY_HALF: begin
        if (key_wr) begin
          st_d = KEY_IDLE;
          if (key_byte == KEY_CLOSE) feed_ok = 1'b1;
          else                       broken  = 1'b1;
        end else if (other_acc) begin
          st_d   = KEY_IDLE;
          broken = 1'b1;
        end
      end
      default: st_d = KEY_IDLE;
    endcase
  end

  assign feed_bad = broken && armed;
  assign key_half = (st_q == KEY_HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdog_down_cnt.sv
`timescale 1ns/1ps
module wdog_down_cnt
  import wdog_feedlock_pkg::*;
#(
  parameter int          CNT_W   = 24,
  parameter logic [31:0] RST_VAL = 32'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign count  = cnt_q;
  assign expire = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= CNT_W'(RST_VAL);
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= CNT_W'(count_step(32'(cnt_q), 32'(load_val)));
  end
endmodule

// File: rtl/wdog_feedlock.sv
`timescale 1ns/1ps
module wdog_feedlock
  import wdog_feedlock_pkg::*;
#(
  parameter int          ADDR_W = 4,
  parameter int          DATA_W = 32,
  parameter int          CNT_W  = 24,
  parameter int          PRE_DIV = 4,
  parameter logic [31:0] TC_MIN = 32'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              wdt_rst_req
);
  localparam logic [31:0] TC_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  // Decoded bus events
  logic acc_wr, hit_mode, hit_reload, hit_key, hit_count;
  logic key_wr, other_acc;

  assign acc_wr     = acc_valid && acc_write;
  assign hit_mode   = (acc_addr == ADDR_W'(OFS_MODE));
  assign hit_reload = (acc_addr == ADDR_W'(OFS_RELOAD));
  assign hit_key    = (acc_addr == ADDR_W'(OFS_KEY));
  assign hit_count  = (acc_addr == ADDR_W'(OFS_COUNT));
  assign key_wr     = acc_wr && hit_key;
  assign other_acc  = acc_valid && !key_wr;

  // Mode and reload state
  logic             en_q, rst_sel_q, flag_q, active_q, rst_req_q;
  logic [CNT_W-1:0] tc_q;

  // Named internal events
  logic             feed_ok, feed_bad, key_half, tick, expire;
  logic [CNT_W-1:0] count;

  wdog_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (acc_wdata[7:0]),
    .other_acc(other_acc),
    .armed    (active_q),
    .feed_ok  (feed_ok),
    .feed_bad (feed_bad),
    .key_half (key_half)
  );

  wdog_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active_q),
    .restart(feed_ok),
    .tick   (tick)
  );

  wdog_down_cnt #(.CNT_W(CNT_W), .RST_VAL(TC_MIN)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (feed_ok),
    .load_val(tc_q),
    .tick    (tick),
    .count   (count),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rst_sel_q <= 1'b0;
      flag_q    <= 1'b0;
      active_q  <= 1'b0;
      rst_req_q <= 1'b0;
      tc_q      <= CNT_W'(TC_MIN);
    end else begin
      if (acc_wr && hit_mode) begin
        if (acc_wdata[0]) en_q <= 1'b1;
        rst_sel_q <= acc_wdata[1];
      end
      if (expire && !rst_sel_q)                     flag_q <= 1'b1;
      else if (acc_wr && hit_mode && !acc_wdata[2]) flag_q <= 1'b0;
      if (acc_wr && hit_reload)
        tc_q <= CNT_W'(clamp_reload(32'(acc_wdata), TC_MIN, TC_MAX));
      if (feed_ok && en_q) active_q <= 1'b1;
      rst_req_q <= (expire && rst_sel_q) || feed_bad;
    end
  end

  assign wdt_rst_req = rst_req_q;

  always_comb begin
    acc_rdata = '0;
    if (hit_mode) begin
      acc_rdata[0] = en_q;
      acc_rdata[1] = rst_sel_q;
      acc_rdata[2] = flag_q;
    end else if (hit_reload) begin
      acc_rdata = DATA_W'(tc_q);
    end else if (hit_count) begin
      acc_rdata = DATA_W'(count);
    end
  end
endmodule

// File: rtl/wdog_feedlock_chk.sv
`timescale 1ns/1ps
module wdog_feedlock_chk #(
  parameter int          CNT_W  = 24,
  parameter logic [31:0] TC_MIN = 32'hFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             active_q,
  input logic             rst_sel_q,
  input logic             tick,
  input logic             expire,
  input logic             feed_ok,
  input logic             feed_bad,
  input logic             key_half,
  input logic             key_wr,
  input logic             acc_valid,
  input logic             wdt_rst_req,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] tc_q
);
  a_r8_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  a_r3_armed_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> en_q);

  a_r3_arms_only_by_feed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(feed_ok));

  a_r3_count_holds_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !feed_ok) |=> $stable(count));

  a_r5_tick_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> active_q);

  a_r2_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tc_q) >= TC_MIN);

  a_r6_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> ($past(expire && rst_sel_q) || $past(feed_bad)));

  a_r4_feed_after_open: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |-> key_half);

  a_r10_abort_on_other: assert property (@(posedge clk) disable iff (!rst_n)
    (key_half && acc_valid && !key_wr) |=> !key_half);

  a_r9_bad_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    feed_bad |-> active_q);
endmodule

bind wdog_feedlock wdog_feedlock_chk #(.CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_q       (en_q),
  .active_q   (active_q),
  .rst_sel_q  (rst_sel_q),
  .tick       (tick),
  .expire     (expire),
  .feed_ok    (feed_ok),
  .feed_bad   (feed_bad),
  .key_half   (key_half),
  .key_wr     (key_wr),
  .acc_valid  (acc_valid),
  .wdt_rst_req(wdt_rst_req),
  .count      (count),
  .tc_q       (tc_q)
);

// File: tb/wdog_feedlock_bench.sv
`timescale 1ns/1ps
module wdog_feedlock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        wdt_rst_req;

  always #2.5 clk = ~clk;

  wdog_feedlock u_wdog_feedlock (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .wdt_rst_req(wdt_rst_req)
  );

  typedef struct {
    string       req;
    logic [31:0] val;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  int cyc = 0, pulses = 0, long_pulses = 0, pulse_cyc = 0;
  bit prev_req = 1'b0, finished = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare reads against the scoreboard, count reset pulses
  always @(negedge clk) begin
    if (rst_n && acc_valid && !acc_write) begin
      if (q.size() == 0) check("scoreboard", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, acc_rdata, e.val);
      end
    end
    if (rst_n && wdt_rst_req) begin
      if (prev_req) long_pulses++;
      else begin
        pulses++;
        pulse_cyc = cyc;
      end
    end
    prev_req = rst_n && wdt_rst_req;
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] v, string req);
    exp_t e;
    e.req = req; e.val = v;
    q.push_back(e);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int base;
    int feed_cyc;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 rst_req", {31'd0, wdt_rst_req}, 32'd0);
    rd(4'h0, 32'h0,  "R1 mode");
    rd(4'h4, 32'hFF, "R1 reload");
    rd(4'hC, 32'hFF, "R1 count");
    rd(4'h8, 32'h0,  "R1 key read");
    // R2 clamp
    wr(4'h4, 32'h10);       rd(4'h4, 32'hFF,     "R2 floor");
    wr(4'h4, 32'h1000000);  rd(4'h4, 32'hFFFFFF, "R2 ceiling");
    wr(4'h4, 32'h300);      rd(4'h4, 32'h300,    "R2 in range");
    // R9/R10 unarmed: no reset
    wr(4'h8, 32'hAA); wr(4'h8, 32'h12); idle(2);
    check("R9 unarmed bad byte", pulses, 0);
    wr(4'h8, 32'hAA); rd(4'h0, 32'h0, "R10 read between"); idle(2);
    check("R10 unarmed abort", pulses, 0);
    // R3 feed without enable reloads, no run
    feed();
    rd(4'hC, 32'h300, "R4 reload on feed");
    idle(12);
    rd(4'hC, 32'h300, "R3 not armed");
    wr(4'hC, 32'h1234);
    rd(4'hC, 32'h300, "R11 count read-only");
    // R3 enable alone
    wr(4'h0, 32'h3);
    rd(4'h0, 32'h3, "R3 mode set");
    idle(10);
    rd(4'hC, 32'h300, "R3 enable alone");
    wr(4'h4, 32'hFF);
    rd(4'hC, 32'h300, "R3 reload write keeps count");
    // R4/R5 arm and tick phase
    feed();
    feed_cyc = cyc;
    rd(4'hC, 32'hFF, "R4 count after arm");
    idle(2);
    rd(4'hC, 32'hFF, "R5 before 4th edge");
    rd(4'hC, 32'hFE, "R5 after 4th edge");
    // R6 expiry pulse
    check("R6 no early pulse", pulses, 0);
    idle(1030);
    check("R6 one pulse", pulses, 1);
    check("R6 pulse time", pulse_cyc - feed_cyc, 1024);
    check("R6 width", long_pulses, 0);
    // R8 enable sticky, R7 flag mode
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h1, "R8 enable kept");
    feed();
    idle(1100);
    check("R7 no pulse", pulses, 1);
    rd(4'h0, 32'h5, "R7 flag set");
    wr(4'h0, 32'h5);
    rd(4'h0, 32'h5, "R7 write 1 keeps flag");
    wr(4'h0, 32'h1);
    rd(4'h0, 32'h1, "R7 write 0 clears flag");
    // R9/R10 armed
    wr(4'h0, 32'h3);
    feed();
    base = pulses;
    wr(4'h8, 32'hAA); wr(4'h8, 32'h12); idle(1);
    check("R9 bad byte", pulses, base + 1);
    wr(4'h8, 32'hAA); rd(4'h0, 32'h3, "R10 read between armed"); idle(1);
    check("R10 abort armed", pulses, base + 2);
    wr(4'h8, 32'hAA); wr(4'h8, 32'hAA); idle(1);
    check("R9 repeated open", pulses, base + 3);
    feed(); idle(2);
    check("R4 good feed no pulse", pulses, base + 3);
    rd(4'hC, 32'hFF, "R11 count after refeed");
    check("R6 all pulses single", long_pulses, 0);
    idle(2);
    check("scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule